// File: doc/BRIEF.md
# Privilege-Checked Address Segment Decoder

This block sits in front of address translation in a 32-bit processor. Each virtual address is sorted into one of five fixed regions by its top three bits. The region is then checked against the current privilege level. The block has no clock and no state, so every output follows the inputs within the same cycle.

A legal access takes one of two paths:
- It is handed on to the translation lookaside buffer (`map_req`).
- It is resolved on the spot to a physical address with read and write permission. This happens in the two direct windows in the upper half, and in the low half while the error-level bit is set.

An illegal access returns an address-error code that tells a load from a store. The block also always presents the values that exception logic loads on any memory fault: the faulting address, a refreshed page-table context word and a refill tag carrying the current address-space identifier. The consumer latches these only when it actually takes a fault.

The decoder carries no data stream and no handshake. Every pin is a plain control or status signal, and a result is valid whenever its inputs are stable.

Top module: `addr_seg_decoder`

## Requirements
- R1: For an address below 0x80000000 with `err_level`=0, every mode is legal: `map_req`=1, `fault_code`=0, `phys_addr`=0, and both permissions are 0.
- R2: For an address below 0x80000000 with `err_level`=1: `map_req`=0, `phys_addr` equals the address, and `perm_rd`=`perm_wr`=1.
- R3: For an address in 0x80000000..0x9FFFFFFF in kernel mode: `map_req`=0, `phys_addr` = address − 0x80000000, and both permissions are 1.
- R4: For an address in 0xA0000000..0xBFFFFFFF in kernel mode: `map_req`=0, `phys_addr` = address − 0xA0000000, and both permissions are 1.
- R5: An address in 0xC0000000..0xDFFFFFFF gives `map_req`=1 in supervisor or kernel mode, and is illegal in user mode.
- R6: An address at 0xE0000000 or above gives `map_req`=1 only in kernel mode, and is illegal otherwise.
- R7: An illegal access gives `fault_code`=2'b10 when `is_store`=1 and 2'b01 when `is_store`=0. It also forces `map_req`=0, `phys_addr`=0 and both permissions to 0. A legal access gives `fault_code`=2'b00.
- R8: `priv_mode` is encoded 2'b00 kernel, 2'b01 supervisor, 2'b10 user. The value 2'b11 is checked exactly as user.
- R9: `bad_vaddr` always equals `vaddr`.
- R10: `ctx_out` is formed as follows:
  - bits 31..23 come from `ctx_hi_in`;
  - bits 22..4 come from `vaddr[31:13]`;
  - bits 3..0 are zero.
- R11: `entryhi_out` is formed as follows:
  - bits 31..13 come from `vaddr[31:13]`;
  - bits 12..8 are zero;
  - bits 7..0 come from `cur_asid`.
- R12: `err_level` has no effect on any output for an address at 0x80000000 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address under test |
| is_store | input | 1 | 1 = write access, 0 = read |
| priv_mode | input | 2 | Privilege level (00 kernel, 01 supervisor, 10/11 user) |
| err_level | input | 1 | Error-level status bit |
| cur_asid | input | 8 | Current address-space identifier |
| ctx_hi_in | input | 9 | Upper bits of the present context word, kept on a fault |
| map_req | output | 1 | Address must be looked up in the TLB |
| phys_addr | output | 32 | Physical address for a resolved unmapped access, else 0 |
| perm_rd | output | 1 | Read permitted on an unmapped access |
| perm_wr | output | 1 | Write permitted on an unmapped access |
| fault_code | output | 2 | 00 none, 01 address error on read, 10 address error on write |
| bad_vaddr | output | 32 | Faulting-address value |
| ctx_out | output | 32 | Context word to load on a fault |
| entryhi_out | output | 32 | Refill tag to load on a fault |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit identifier and a 13-bit page-pair offset. With these values the zero gap between the identifier and the page number in `entryhi_out` can be seen, and so can the four cleared bits at the foot of `ctx_out`. The stimulus walks the edge addresses of every region, including each first and last word, under all four mode codes with both access directions and both error-level settings. Identifier and context-bit patterns are varied so that a field placed at the wrong offset would show.

// File: rtl/addr_seg_pkg.sv
package addr_seg_pkg;
  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUP  = 2'b01,
    MODE_USER = 2'b10,
    MODE_RSVD = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    SEG_LOW   = 3'd0,
    SEG_DIRC  = 3'd1,
    SEG_DIRU  = 3'd2,
    SEG_SUPM  = 3'd3,
    SEG_KMAP  = 3'd4
  } seg_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_ADDR_RD = 2'b01,
    FLT_ADDR_WR = 2'b10
  } fault_e;
endpackage

// File: rtl/seg_classify.sv
module seg_classify
  import addr_seg_pkg::*;
(
  input  logic [2:0] top_bits,
  output seg_e       seg
);
  always_comb begin
    unique case (top_bits)
      3'd4:    seg = SEG_DIRC;
      3'd5:    seg = SEG_DIRU;
      3'd6:    seg = SEG_SUPM;
      3'd7:    seg = SEG_KMAP;
      default: seg = SEG_LOW;
    endcase
  end
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
  import addr_seg_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] mode,
  output logic       legal
);
  logic is_kern, is_sup;
  always_comb begin
    is_kern = (mode == MODE_KERN);
    is_sup  = (mode == MODE_SUP);
    unique case (seg)
      SEG_LOW:  legal = 1'b1;
      SEG_SUPM: legal = is_kern | is_sup;
      default:  legal = is_kern;
    endcase
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import addr_seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  seg_e              seg,
  input  logic              err_level,
  input  logic [ADDR_W-1:0] vaddr,
  output logic              is_mapped,
  output logic [ADDR_W-1:0] direct_pa
);
  localparam int WIN_W = ADDR_W - 3;

  always_comb begin
    is_mapped = 1'b0;
    direct_pa = '0;
    unique case (seg)
      SEG_LOW: begin
        is_mapped = ~err_level;
        direct_pa = err_level ? vaddr : '0;
      end
      SEG_DIRC, SEG_DIRU: direct_pa = {3'b000, vaddr[WIN_W-1:0]};
      default: is_mapped = 1'b1;
    endcase
  end
endmodule

// File: rtl/fault_report.sv
module fault_report #(
  parameter int ADDR_W     = 32,
  parameter int ASID_W     = 8,
  parameter int PAIR_SHIFT = 13,
  parameter int CTX_LSB    = 4
) (
  input  logic [ADDR_W-PAIR_SHIFT-1:0]        vpn2,
  input  logic [ASID_W-1:0]                   asid,
  input  logic [ADDR_W-(ADDR_W-PAIR_SHIFT+CTX_LSB)-1:0] ctx_hi,
  output logic [ADDR_W-1:0]                   ctx_word,
  output logic [ADDR_W-1:0]                   tag_word
);
  localparam int GAP_W = PAIR_SHIFT - ASID_W;

  assign ctx_word = {ctx_hi, vpn2, {CTX_LSB{1'b0}}};

  generate
    if (GAP_W > 0) begin : g_gap
      assign tag_word = {vpn2, {GAP_W{1'b0}}, asid};
    end else begin : g_nogap
      assign tag_word = {vpn2, asid[PAIR_SHIFT-1:0]};
    end
  endgenerate
endmodule

// File: rtl/addr_seg_decoder.sv
module addr_seg_decoder
  import addr_seg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ASID_W     = 8,
  parameter int PAIR_SHIFT = 13,
  parameter int CTX_LSB    = 4,
  localparam int VPN_W     = ADDR_W - PAIR_SHIFT,
  localparam int CTX_HI_W  = ADDR_W - (VPN_W + CTX_LSB)
) (
  input  logic [ADDR_W-1:0]   vaddr,
  input  logic                is_store,
  input  logic [1:0]          priv_mode,
  input  logic                err_level,
  input  logic [ASID_W-1:0]   cur_asid,
  input  logic [CTX_HI_W-1:0] ctx_hi_in,
  output logic                map_req,
  output logic [ADDR_W-1:0]   phys_addr,
  output logic                perm_rd,
  output logic                perm_wr,
  output logic [1:0]          fault_code,
  output logic [ADDR_W-1:0]   bad_vaddr,
  output logic [ADDR_W-1:0]   ctx_out,
  output logic [ADDR_W-1:0]   entryhi_out
);
  seg_e              seg;
  logic              legal, is_mapped;
  logic [ADDR_W-1:0] direct_pa;

  seg_classify u_cls (.top_bits(vaddr[ADDR_W-1 -: 3]), .seg(seg));

  seg_priv_check u_chk (.seg(seg), .mode(priv_mode), .legal(legal));

  seg_xlate #(.ADDR_W(ADDR_W)) u_xl (
    .seg(seg), .err_level(err_level), .vaddr(vaddr),
    .is_mapped(is_mapped), .direct_pa(direct_pa)
  );

  fault_report #(
    .ADDR_W(ADDR_W), .ASID_W(ASID_W), .PAIR_SHIFT(PAIR_SHIFT), .CTX_LSB(CTX_LSB)
  ) u_rep (
    .vpn2(vaddr[ADDR_W-1:PAIR_SHIFT]), .asid(cur_asid), .ctx_hi(ctx_hi_in),
    .ctx_word(ctx_out), .tag_word(entryhi_out)
  );

  always_comb begin
    map_req    = legal & is_mapped;
    phys_addr  = (legal & ~is_mapped) ? direct_pa : '0;
    perm_rd    = legal & ~is_mapped;
    perm_wr    = legal & ~is_mapped;
    fault_code = legal ? FLT_NONE : (is_store ? FLT_ADDR_WR : FLT_ADDR_RD);
    bad_vaddr  = vaddr;
  end

  always_comb begin
    // R7
    fault_excl_chk: assert (fault_code == 2'b00 || !(map_req || perm_rd || perm_wr));
    // R7
    if (fault_code != 2'b00) begin
      fault_dir_chk: assert (fault_code == (is_store ? 2'b10 : 2'b01));
    end
    // R8
    if (priv_mode[1] && vaddr[ADDR_W-1]) begin
      user_upper_chk: assert (fault_code != 2'b00);
    end
    // R2
    if (!vaddr[ADDR_W-1] && err_level) begin
      erl_pass_chk: assert (phys_addr == vaddr && !map_req);
    end
    // R3
    if (vaddr[ADDR_W-1] && perm_rd) begin
      direct_win_chk: assert (phys_addr[ADDR_W-1 -: 3] == 3'b000);
    end
  end
endmodule

// File: tb/addr_seg_decoder_test.sv
module addr_seg_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_store = 1'b0;
  logic [1:0]  priv_mode = 2'b00;
  logic        err_level = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic [8:0]  ctx_hi_in = '0;
  logic        map_req, perm_rd, perm_wr;
  logic [31:0] phys_addr, bad_vaddr, ctx_out, entryhi_out;
  logic [1:0]  fault_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_seg_decoder uut (
    .vaddr(vaddr), .is_store(is_store), .priv_mode(priv_mode),
    .err_level(err_level), .cur_asid(cur_asid), .ctx_hi_in(ctx_hi_in),
    .map_req(map_req), .phys_addr(phys_addr), .perm_rd(perm_rd),
    .perm_wr(perm_wr), .fault_code(fault_code), .bad_vaddr(bad_vaddr),
    .ctx_out(ctx_out), .entryhi_out(entryhi_out)
  );

  typedef struct {
    string       tag;
    logic        map;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
    logic [1:0]  flt;
    logic [31:0] bad;
    logic [31:0] ctx;
    logic [31:0] ehi;
  } exp_t;

  exp_t sb[$];

  function automatic exp_t model(string tag, logic [31:0] a, logic st,
                                 logic [1:0] m, logic erl, logic [7:0] asid,
                                 logic [8:0] ch);
    exp_t e;
    bit kern, sup, ok, mapped;
    logic [31:0] pa;
    kern = (m == 2'b00);
    sup  = (m == 2'b01);
    pa = 32'h0;
    mapped = 0;
    if (a < 32'h8000_0000) begin
      ok = 1;
      mapped = !erl;
      pa = a;
    end else if (a < 32'hA000_0000) begin
      ok = kern;
      pa = a - 32'h8000_0000;
    end else if (a < 32'hC000_0000) begin
      ok = kern;
      pa = a - 32'hA000_0000;
    end else if (a < 32'hE000_0000) begin
      ok = kern || sup;
      mapped = 1;
    end else begin
      ok = kern;
      mapped = 1;
    end
    e.tag = tag;
    e.map = ok && mapped;
    e.pa  = (ok && !mapped) ? pa : 32'h0;
    e.rd  = ok && !mapped;
    e.wr  = ok && !mapped;
    e.flt = ok ? 2'b00 : (st ? 2'b10 : 2'b01);
    e.bad = a;
    e.ctx = {ch, a[31:13], 4'h0};
    e.ehi = {a[31:13], 5'h0, asid};
    return e;
  endfunction

  task automatic drive(string tag, logic [31:0] a, logic st, logic [1:0] m,
                       logic erl, logic [7:0] asid, logic [8:0] ch);
    @(posedge clk);
    vaddr <= a; is_store <= st; priv_mode <= m; err_level <= erl;
    cur_asid <= asid; ctx_hi_in <= ch;
    sb.push_back(model(tag, a, st, m, erl, asid, ch));
  endtask

  task automatic cmp32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp32(e.tag, "map_req", {31'h0, map_req}, {31'h0, e.map});
      cmp32(e.tag, "phys_addr", phys_addr, e.pa);
      cmp32(e.tag, "perm", {30'h0, perm_rd, perm_wr}, {30'h0, e.rd, e.wr});
      cmp32(e.tag, "fault_code", {30'h0, fault_code}, {30'h0, e.flt});
      cmp32("R9", "bad_vaddr", bad_vaddr, e.bad);
      cmp32("R10", "ctx_out", ctx_out, e.ctx);
      cmp32("R11", "entryhi_out", entryhi_out, e.ehi);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs, kernel, low region mapped (R1)
    drive("R1", 32'h0, 0, 2'b00, 0, 8'h00, 9'h000);
    for (int m = 0; m < 4; m++) begin
      drive("R1", 32'h7FFF_FFFF, 0, m[1:0], 0, 8'hA5, 9'h1FF);
      drive("R2", 32'h1234_5678, 1, m[1:0], 1, 8'h3C, 9'h0AA);
      drive("R2", 32'h7FFF_E000, 0, m[1:0], 1, 8'hFF, 9'h155);
      drive("R3", 32'h8000_0000, 0, m[1:0], 0, 8'h01, 9'h100);
      drive("R3", 32'h9FFF_FFFF, 1, m[1:0], 0, 8'h80, 9'h001);
      drive("R4", 32'hA000_0000, 1, m[1:0], 0, 8'h5A, 9'h0F0);
      drive("R4", 32'hBFFF_FFFC, 0, m[1:0], 0, 8'h7E, 9'h10F);
      drive("R5", 32'hC000_0000, 0, m[1:0], 0, 8'h11, 9'h033);
      drive("R5", 32'hDFFF_FFFF, 1, m[1:0], 0, 8'h22, 9'h0CC);
      drive("R6", 32'hE000_0000, 1, m[1:0], 0, 8'h44, 9'h1E1);
      drive("R6", 32'hFFFF_FFFF, 0, m[1:0], 0, 8'h88, 9'h01E);
      drive("R7", 32'hC000_2000, 1, m[1:0], 0, 8'h99, 9'h066);
      drive("R7", 32'hF123_4567, 0, m[1:0], 0, 8'h0F, 9'h199);
      // R12: error level set on upper regions changes nothing
      drive("R12", 32'h8ABC_DEF0, 0, m[1:0], 1, 8'h6B, 9'h0B6);
      drive("R12", 32'hB000_1000, 1, m[1:0], 1, 8'hC3, 9'h16D);
      drive("R12", 32'hD55A_AA55, 0, m[1:0], 1, 8'h2D, 9'h0DB);
      drive("R12", 32'hE800_0000, 1, m[1:0], 1, 8'hD2, 9'h124);
    end
    // R8: reserved mode code behaves as user
    drive("R8", 32'h8000_1000, 1, 2'b11, 0, 8'h10, 9'h000);
    drive("R8", 32'hC800_0000, 0, 2'b11, 0, 8'h20, 9'h000);
    drive("R8", 32'h0000_1000, 0, 2'b11, 0, 8'h30, 9'h000);
    drive("R10", 32'hAAAA_AAAA, 0, 2'b00, 0, 8'h55, 9'h155);
    drive("R11", 32'h5555_5555, 1, 2'b01, 0, 8'hAA, 9'h0AA);
    @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule